// File: doc/BRIEF.md
# Memory-Stall Group Scheduler

This block decides which of several resident thread groups owns a shared execution unit in each cycle. A group keeps issuing until the pipeline reports that it has reached a memory operation. The scheduler then parks that group and hands the unit to another ready group on the next cycle, so memory latency is covered by useful work from the other groups. A parked group comes back into the candidate set only after its memory-completion pulse arrives.

The replacement is chosen round-robin. The search starts just after the group that issued last and wraps through the group indices in rising order, so no ready group waits forever. When every resident group is parked, the issue-valid flag drops until a completion arrives. The block also reports how many groups are resident. Dividing that count by the group capacity, `NUM_GROUPS` (default 4), gives the occupancy ratio.

Top module: `stall_switch_sched`

## Requirements
- R1: While reset (`rstN` low) is held, and in the first cycle after it, `issueValid` is 0 and `occupancy` is 0 as long as no `groupValid` bit has been sampled high.
- R2: When the scheduler is idle and at least one group is valid and not parked, `issueValid` rises one cycle later. The chosen group is the first ready index found by searching upward from the last issued group plus one and wrapping. After reset the search starts at index 0.
- R3: While the issuing group stays valid and raises no stall, `issueGroup` and `issueValid` hold their values, with no time-slice switching.
- R4: A stall request (`stallReq[i]` high with `i == issueGroup` and `issueValid` high) parks group i. In the next cycle `issueGroup` is the first ready index after i, in cyclic order, and `issueValid` stays 1 if any group is ready, leaving no idle issue cycle.
- R5: A parked group is never chosen until a `memDone` pulse for that group has been seen. After a pulse in cycle t, the group is eligible for the selection made at the end of cycle t.
- R6: When no valid group is ready, `issueValid` is 0 from the next cycle. It rises again in the cycle after a completion pulse makes a group ready.
- R7: When `stallReq` and `memDone` are both high for the issuing group in the same cycle, the stall wins and the group stays parked.
- R8: A `stallReq` bit for a group that is not the issuing group has no effect.
- R9: `occupancy` equals the number of set bits that `groupValid` had in the previous cycle.
- R10: A group whose `groupValid` bit is low is never chosen. If the issuing group loses its valid bit, the scheduler reselects in the next cycle as for a stall.

Parameter: `NUM_GROUPS` (default 4, at least 2). `GW = $clog2(NUM_GROUPS)`. `CW = $clog2(NUM_GROUPS+1)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| groupValid | input | NUM_GROUPS | Bit i high: group i is resident |
| stallReq | input | NUM_GROUPS | Bit i high: group i reached a memory operation |
| memDone | input | NUM_GROUPS | Bit i pulse: memory request of group i is complete |
| issueGroup | output | GW | Index of the group that issues this cycle |
| issueValid | output | 1 | `issueGroup` is meaningful this cycle |
| occupancy | output | CW | Count of resident groups |

## Verification
The hardest case to reach is a stall request and a completion pulse for the same group in the same cycle. It matters only if the group's later eligibility is observed. The stimulus first parks every other group, then applies both pulses together, then stalls the only remaining ready group. If the stall has won, issue must go idle; if the completion had won, the group would reappear at once. Round-robin wrap-around and the request for a group that is not issuing are reached the same way: parked sets are built up with chosen completions, so that exactly one selection is correct.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic stallTake;   // issuing group is parked this cycle
    logic switchEn;    // a new selection is loaded this cycle
  } schedStrobes_t;
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int NUM_GROUPS = 4,
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0] readyVec,
  input  logic [GW-1:0]         baseIdx,
  output logic [GW-1:0]         pickIdx,
  output logic                  anyReady
);
  // Search starts one above baseIdx and wraps; baseIdx itself is tried last.
  always_comb begin
    int idx;
    pickIdx  = '0;
    anyReady = 1'b0;
    for (int k = 1; k <= NUM_GROUPS; k++) begin
      idx = (int'(baseIdx) + k) % NUM_GROUPS;
      if (!anyReady && readyVec[idx]) begin
        anyReady = 1'b1;
        pickIdx  = idx[GW-1:0];
      end
    end
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0] groupValid,
  input  logic [NUM_GROUPS-1:0] stallReq,
  input  logic [GW-1:0]         curGroup,
  input  logic                  curValid,
  output schedStrobes_t         strobes
);
  logic curStillValid;

  assign curStillValid = groupValid[curGroup];

  always_comb begin
    strobes.stallTake = curValid & curStillValid & stallReq[curGroup];
    strobes.switchEn  = ~curValid | ~curStillValid | strobes.stallTake;
  end
endmodule

// File: rtl/sched_dpath.sv
module sched_dpath
  import sched_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GW = $clog2(NUM_GROUPS),
  localparam int CW = $clog2(NUM_GROUPS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] groupValid,
  input  logic [NUM_GROUPS-1:0] memDone,
  input  schedStrobes_t         strobes,
  output logic [GW-1:0]         curGroup,
  output logic                  curValid,
  output logic [CW-1:0]         occCount
);
  logic [NUM_GROUPS-1:0] parked;
  logic [NUM_GROUPS-1:0] parkedNxt;
  logic [NUM_GROUPS-1:0] readyNxt;
  logic [GW-1:0]         pickIdx;
  logic                  anyReady;
  logic [CW-1:0]         validCount;

  // Per-group parked bit: the stall wins over a completion in the same cycle
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_park
    logic parkHit;
    assign parkHit      = strobes.stallTake && (curGroup == GW'(g));
    assign parkedNxt[g] = groupValid[g] & (parkHit | (parked[g] & ~memDone[g]));
    assign readyNxt[g]  = groupValid[g] & ~parkedNxt[g];
  end

  sched_rr_pick #(.NUM_GROUPS(NUM_GROUPS)) pick_i (
    .readyVec (readyNxt),
    .baseIdx  (curGroup),
    .pickIdx  (pickIdx),
    .anyReady (anyReady)
  );

  always_comb begin
    validCount = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      validCount = validCount + CW'(groupValid[g]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parked   <= '0;
      curGroup <= GW'(NUM_GROUPS - 1);
      curValid <= 1'b0;
      occCount <= '0;
    end else begin
      parked   <= parkedNxt;
      occCount <= validCount;
      if (strobes.switchEn) begin
        curValid <= anyReady;
        if (anyReady) begin
          curGroup <= pickIdx;
        end
      end
    end
  end
endmodule

// File: rtl/stall_switch_sched.sv
module stall_switch_sched
  import sched_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GW = $clog2(NUM_GROUPS),
  localparam int CW = $clog2(NUM_GROUPS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] groupValid,
  input  logic [NUM_GROUPS-1:0] stallReq,
  input  logic [NUM_GROUPS-1:0] memDone,
  output logic [GW-1:0]         issueGroup,
  output logic                  issueValid,
  output logic [CW-1:0]         occupancy
);
  schedStrobes_t strobes;
  logic [GW-1:0] curGroup;
  logic          curValid;

  sched_ctrl #(.NUM_GROUPS(NUM_GROUPS)) ctrl_i (
    .groupValid (groupValid),
    .stallReq   (stallReq),
    .curGroup   (curGroup),
    .curValid   (curValid),
    .strobes    (strobes)
  );

  sched_dpath #(.NUM_GROUPS(NUM_GROUPS)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .groupValid (groupValid),
    .memDone    (memDone),
    .strobes    (strobes),
    .curGroup   (curGroup),
    .curValid   (curValid),
    .occCount   (occupancy)
  );

  assign issueGroup = curGroup;
  assign issueValid = curValid;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NUM_GROUPS = 4,
  localparam int GW = $clog2(NUM_GROUPS),
  localparam int CW = $clog2(NUM_GROUPS + 1)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_GROUPS-1:0] groupValid,
  input logic [NUM_GROUPS-1:0] stallReq,
  input logic [GW-1:0]         issueGroup,
  input logic                  issueValid,
  input logic [CW-1:0]         occupancy
);
  logic [NUM_GROUPS-1:0] prevValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= '0;
    else       prevValid <= groupValid;
  end

  // R3: no switch without a stall or a loss of valid
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && groupValid[issueGroup] && !stallReq[issueGroup])
      |=> (issueValid && $stable(issueGroup)));

  // R4: a stalled issuing group does not issue in the next cycle
  p_switch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && groupValid[issueGroup] && stallReq[issueGroup])
      |=> (!issueValid || issueGroup != $past(issueGroup)));

  // R9: occupancy tracks the previous valid vector
  p_occ_r9: assert property (@(posedge clk) disable iff (!rstN)
    occupancy == CW'($countones(prevValid)));

  // R10: only a group valid at the selecting edge is issued
  p_valid_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> prevValid[issueGroup]);

  // R1: idle straight after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !issueValid);
endmodule

bind stall_switch_sched sched_checker #(.NUM_GROUPS(NUM_GROUPS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .groupValid (groupValid),
  .stallReq   (stallReq),
  .issueGroup (issueGroup),
  .issueValid (issueValid),
  .occupancy  (occupancy)
);

// File: tb/stall_switch_sched_tb.sv
module stall_switch_sched_tb_top;
  localparam int N  = 4;
  localparam int GW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  groupValid = '0;
  logic [N-1:0]  stallReq = '0;
  logic [N-1:0]  memDone = '0;
  logic [GW-1:0] issueGroup;
  logic          issueValid;
  logic [CW-1:0] occupancy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stall_switch_sched #(.NUM_GROUPS(N)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .groupValid (groupValid),
    .stallReq   (stallReq),
    .memDone    (memDone),
    .issueGroup (issueGroup),
    .issueValid (issueValid),
    .occupancy  (occupancy)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkIssue(string tag, int expValid, int expGroup);
    checkEq({tag, " valid"}, int'(issueValid), expValid);
    if (expValid != 0) checkEq({tag, " group"}, int'(issueGroup), expGroup);
  endtask

  task automatic stallPulse(int g);
    stallReq[g] = 1'b1;
    step();
    stallReq[g] = 1'b0;
  endtask

  task automatic donePulse(int g);
    memDone[g] = 1'b1;
    step();
    memDone[g] = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    groupValid = '0;
    step();
    step();
    checkIssue("R1 in reset", 0, 0);
    checkEq("R1 occupancy in reset", int'(occupancy), 0);
    rstN = 1'b1;
    step();
    checkIssue("R1 after release", 0, 0);
    checkEq("R1 occupancy after release", int'(occupancy), 0);
  endtask

  task automatic testStartHold();
    groupValid = 4'b1111;
    step();
    checkIssue("R2 first pick", 1, 0);
    checkEq("R9 occupancy four", int'(occupancy), 4);
    for (int i = 0; i < 3; i++) step();
    checkIssue("R3 hold without stall", 1, 0);
  endtask

  task automatic testStallChain();
    stallPulse(0);
    checkIssue("R4 switch 0->1", 1, 1);
    stallPulse(1);
    checkIssue("R4 switch 1->2", 1, 2);
    stallPulse(2);
    checkIssue("R4 switch 2->3", 1, 3);
    stallPulse(3);
    checkIssue("R6 all parked idle", 0, 0);
    donePulse(2);
    checkIssue("R6 resume on completion", 1, 2);
    donePulse(0);
    donePulse(1);
    checkIssue("R3 completion of others no switch", 1, 2);
    stallPulse(2);
    checkIssue("R4 wrap 2->0 skipping parked 3", 1, 0);
  endtask

  task automatic testConflict();
    stallReq[0] = 1'b1;
    memDone[0]  = 1'b1;
    step();
    stallReq[0] = 1'b0;
    memDone[0]  = 1'b0;
    checkIssue("R7 stall with done switches", 1, 1);
    stallPulse(1);
    checkIssue("R7 group 0 still parked", 0, 0);
    donePulse(3);
    checkIssue("R5 completion of 3 makes it eligible", 1, 3);
    donePulse(0);
    donePulse(2);
    donePulse(1);
    checkIssue("R5 holding 3", 1, 3);
  endtask

  task automatic testIgnore();
    stallPulse(0);
    checkIssue("R8 stall of non-issuing ignored", 1, 3);
    stallPulse(3);
    checkIssue("R8 group 0 not parked", 1, 0);
    stallPulse(0);
    checkIssue("R4 switch 0->1", 1, 1);
  endtask

  task automatic testInvalid();
    groupValid = 4'b1101;
    step();
    checkIssue("R10 reselect on valid loss", 1, 2);
    checkEq("R9 occupancy three", int'(occupancy), 3);
    stallPulse(2);
    checkIssue("R10 invalid group not chosen", 0, 0);
    donePulse(1);
    checkIssue("R10 done for invalid group no issue", 0, 0);
    groupValid = 4'b1111;
    step();
    checkIssue("R2 idle pick after 2", 1, 1);
    checkEq("R9 occupancy back to four", int'(occupancy), 4);
  endtask

  initial begin
    testReset();
    testStartHold();
    testStallChain();
    testConflict();
    testIgnore();
    testInvalid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule